// File: doc/BRIEF.md
# Transfer-Budget Bank Arbiter

This block decides which of four masters may use one memory bank. A chip uses one copy of it for each bank, so the banks are arbitrated independently. Each master has a programmed transfer budget for this bank. A master that wins the bank keeps it until one of three things happens: it has completed that many transfers, it lowers its request, or the owner master takes the bank. When the grant ends, the next holder is chosen round-robin, starting with the master after the one that last held the bank. No master can therefore hold the bank for ever while others wait.

One master may be named the owner of the bank. While the owner is requesting, it wins every free arbitration. If another master holds the bank when the owner raises its request, that master keeps the bank only until its current transfer completes. After that the bank goes to the owner.

The granted master reports each completed transfer by pulsing `beat` for one cycle. `beat` is a plain control pin, and the arbiter applies no back-pressure to it. A beat that arrives while no master holds the grant is ignored. The configuration inputs are read only when a grant is issued, so they should be changed only while the bank is idle.

Top module: `xfer_budget_arbiter`

## Requirements
- R1: After reset, `grant` is all zeros and `grant_valid` is 0.
- R2: `grant` has at most one bit set. `grant_valid` is 1 exactly when one bit of `grant` is set. Bit i of `grant` belongs to master i, and master i requests on bit i of `req`.
- R3: A grant is given only to a master whose `req` bit was 1 at the clock edge where the grant was issued. The grant changes only at a rising clock edge.
- R4: The budget of master i is field i of `budget_cfg`, which is bits [i*CNT_W +: CNT_W]. The budget is loaded when the grant is issued. The grant ends at the edge that accepts the beat that uses up the budget.
- R5: A budget field of 0 is treated as a budget of 1: the grant ends after one beat.
- R6: If the granted master has `req` low at an edge, its grant ends at that edge, even if budget remains.
- R7: When the bank is free, the grant goes to the first requesting master found by counting upward from the last holder plus one, wrapping modulo 4. After reset, the last holder is taken to be master 3, so the search starts at master 0.
- R8: With `owner_en` at 1, a free bank goes to master `owner_id` whenever that master is requesting.
- R9: With `owner_en` at 1, if a different master holds the bank and the owner is requesting, the grant passes to the owner at the next beat.
- R10: While the granted master keeps requesting and no beat arrives, the grant does not change.
- R11: A beat while no master is granted has no effect: the next grant still starts with its full budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_MASTERS | One request line per master |
| beat | input | 1 | The granted master completed one transfer this cycle |
| budget_cfg | input | N_MASTERS*CNT_W | Transfer budget for each master, field i for master i |
| owner_en | input | 1 | Turns owner priority on |
| owner_id | input | $clog2(N_MASTERS) | Index of the owner master |
| grant | output | N_MASTERS | One-hot grant |
| grant_valid | output | 1 | Some master holds the bank |

## Verification
The assertions check on every cycle that the grant is one-hot and agrees with `grant_valid`. They also check that a new grant goes only to a master that was requesting, that a dropped request ends the grant, that the grant holds steady without beats, and that an idle bank goes to a requesting owner. Some behaviour spans a whole grant, and only the bench scenarios show it: budget exhaustion after exactly the programmed number of beats, a zero budget counting as one beat, round-robin order across successive grants, owner preemption at the in-flight beat, and stray beats while idle being ignored. The random phases compare every cycle with a model in the bench that is written from the requirements.

// File: rtl/xba_pkg.sv
package xba_pkg;
  localparam int unsigned DEF_MASTERS = 4;
  localparam int unsigned DEF_CNT_W   = 4;

  // A zero budget still allows one transfer.
  function automatic logic [31:0] eff_budget(input logic [31:0] raw);
    return (raw == 32'd0) ? 32'd1 : raw;
  endfunction
endpackage

// File: rtl/xba_pick.sv
module xba_pick #(
  parameter int unsigned N  = 4,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last_idx,
  input  logic          owner_en,
  input  logic [IW-1:0] owner_id,
  output logic          pick_valid,
  output logic [IW-1:0] pick_idx
);
  logic          rr_found;
  logic [IW-1:0] rr_idx;

  always_comb begin
    rr_found = 1'b0;
    rr_idx   = '0;
    for (int k = 1; k <= N; k++) begin
      int unsigned cand;
      cand = (int'(last_idx) + k) % N;
      if (!rr_found && req[cand]) begin
        rr_found = 1'b1;
        rr_idx   = IW'(cand);
      end
    end
  end

  always_comb begin
    if (owner_en && req[owner_id]) begin
      pick_valid = 1'b1;
      pick_idx   = owner_id;
    end else begin
      pick_valid = rr_found;
      pick_idx   = rr_idx;
    end
  end

  // R3
  always_comb begin
    found_req_chk: assert (!pick_valid || req[pick_idx]);
  end
endmodule

// File: rtl/xba_budget.sv
module xba_budget #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          last_beat
);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      left_q <= '0;
    else if (load)
      left_q <= (load_val == '0) ? CW'(1) : load_val;
    else if (dec && left_q != '0)
      left_q <= left_q - CW'(1);
  end

  assign last_beat = (left_q == CW'(1));

  // R4
  budget_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> left_q != '0);
endmodule

// File: rtl/xfer_budget_arbiter.sv
module xfer_budget_arbiter
  import xba_pkg::*;
#(
  parameter int unsigned N_MASTERS = DEF_MASTERS,
  parameter int unsigned CNT_W     = DEF_CNT_W,
  localparam int unsigned IW       = $clog2(N_MASTERS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_MASTERS-1:0]       req,
  input  logic                       beat,
  input  logic [N_MASTERS*CNT_W-1:0] budget_cfg,
  input  logic                       owner_en,
  input  logic [IW-1:0]              owner_id,
  output logic [N_MASTERS-1:0]       grant,
  output logic                       grant_valid
);
  logic          gv_q;
  logic [IW-1:0] hold_q;
  logic          pick_valid;
  logic [IW-1:0] pick_idx;
  logic          last_beat;
  logic          owner_wait, end_grant, bank_free, do_load;

  xba_pick #(.N(N_MASTERS)) u_pick (
    .req(req), .last_idx(hold_q), .owner_en(owner_en), .owner_id(owner_id),
    .pick_valid(pick_valid), .pick_idx(pick_idx)
  );

  assign owner_wait = owner_en && req[owner_id] && (owner_id != hold_q);
  assign end_grant  = gv_q && (!req[hold_q] || (beat && (last_beat || owner_wait)));
  assign bank_free  = !gv_q || end_grant;
  assign do_load    = bank_free && pick_valid;

  xba_budget #(.CW(CNT_W)) u_budget (
    .clk(clk), .rst_n(rst_n), .load(do_load),
    .load_val(budget_cfg[pick_idx*CNT_W +: CNT_W]),
    .dec(gv_q && beat), .last_beat(last_beat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gv_q   <= 1'b0;
      hold_q <= IW'(N_MASTERS - 1);
    end else if (bank_free) begin
      gv_q <= pick_valid;
      if (pick_valid) hold_q <= pick_idx;
    end
  end

  always_comb begin
    grant = '0;
    if (gv_q) grant[hold_q] = 1'b1;
  end
  assign grant_valid = gv_q;

  // R2
  onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (grant_valid == (grant != '0)));

  // R3
  granted_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !$stable(grant)) |-> (($past(req) & grant) != '0));

  // R6
  drop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && ((grant & req) == '0)) |=> ((grant & $past(grant)) == '0));

  // R10
  hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && ((grant & req) != '0) && !beat) |=> $stable(grant));

  // R8
  owner_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && owner_en && req[owner_id]) |=> grant[$past(owner_id)]);
endmodule

// File: tb/xfer_budget_arbiter_bench.sv
module xfer_budget_arbiter_bench;
  localparam int N  = 4;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic          beat = 1'b0;
  logic [N*CW-1:0] budget_cfg = '0;
  logic          owner_en = 1'b0;
  logic [1:0]    owner_id = 2'd0;
  logic [N-1:0]  grant;
  logic          grant_valid;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference state
  bit     m_gv;
  int     m_idx;
  int     m_left;

  always #2.5 clk = ~clk;

  xfer_budget_arbiter u_xfer_budget_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .beat(beat), .budget_cfg(budget_cfg),
    .owner_en(owner_en), .owner_id(owner_id), .grant(grant), .grant_valid(grant_valid)
  );

  function automatic int cfg_of(int m);
    int v;
    v = int'(budget_cfg[m*CW +: CW]);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int rr_from(int last);
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (last + k) % N;
      if (req[c]) return c;
    end
    return -1;
  endfunction

  function automatic logic [N-1:0] model_grant();
    logic [N-1:0] g;
    g = '0;
    if (m_gv) g[m_idx] = 1'b1;
    return g;
  endfunction

  task automatic model_edge();
    bit ending, free;
    int nxt;
    ending = 0;
    if (m_gv) begin
      if (!req[m_idx]) ending = 1;
      else if (beat && (m_left == 1 ||
               (owner_en && req[owner_id] && int'(owner_id) != m_idx))) ending = 1;
      else if (beat) m_left--;
    end
    free = !m_gv || ending;
    if (free) begin
      if (owner_en && req[owner_id]) nxt = int'(owner_id);
      else nxt = rr_from(m_idx);
      m_gv = (nxt >= 0);
      if (nxt >= 0) begin
        m_idx  = nxt;
        m_left = cfg_of(nxt);
      end
    end
  endtask

  task automatic check(string tag, logic [N-1:0] exp_g);
    total++;
    if (grant !== exp_g || grant_valid !== (exp_g != '0)) begin
      bad++;
      $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b",
               tag, grant, grant_valid, exp_g, exp_g != '0);
    end
  endtask

  // drive inputs at negedge, update model at the edge, compare at next negedge
  task automatic step(logic [N-1:0] r, logic b, string tag);
    req  = r;
    beat = b;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, model_grant());
  endtask

  task automatic reset_all();
    rst_n = 1'b0;
    req = '0; beat = 1'b0;
    @(posedge clk); @(posedge clk);
    m_gv = 0; m_idx = N - 1; m_left = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_gv = 0; m_idx = N - 1; m_left = 0;
    @(negedge clk);
    reset_all();
    // R1: reset state
    check("R1 reset", 4'b0000);

    // R4 R7: budget 3 for master 1, master 2 waits
    budget_cfg = {4'd2, 4'd0, 4'd3, 4'd2};
    step(4'b0110, 1'b0, "R7 first pick");
    check("R7 literal m1", 4'b0010);
    step(4'b0110, 1'b1, "R4 beat1");
    step(4'b0110, 1'b1, "R4 beat2");
    check("R4 still m1", 4'b0010);
    step(4'b0110, 1'b1, "R4 beat3");
    check("R4 budget gone -> m2", 4'b0100);
    // R5: zero budget gives one beat
    step(4'b0110, 1'b0, "R10 hold");
    check("R10 literal", 4'b0100);
    step(4'b0110, 1'b1, "R5 single beat");
    check("R5 back to m1", 4'b0010);
    // R6: drop request
    step(4'b0100, 1'b0, "R6 drop");
    check("R6 literal m2", 4'b0100);
    step(4'b0000, 1'b0, "R6 idle");
    check("R6 idle literal", 4'b0000);
    // R11: beats while idle ignored, then full budget of master 0 (2)
    step(4'b0000, 1'b1, "R11 idle beat");
    step(4'b0000, 1'b1, "R11 idle beat");
    step(4'b0011, 1'b0, "R11 grant m0");
    check("R11 m0 granted", 4'b0001);
    step(4'b0011, 1'b1, "R11 beat1");
    check("R11 full budget kept", 4'b0001);
    step(4'b0011, 1'b1, "R11 beat2");
    check("R11 to m1", 4'b0010);
    // R9: owner 3 preempts at next beat
    owner_en = 1'b1; owner_id = 2'd3;
    step(4'b1010, 1'b0, "R9 owner waits");
    check("R9 no preempt without beat", 4'b0010);
    step(4'b1010, 1'b1, "R9 preempt");
    check("R9 owner literal", 4'b1000);
    // R8: owner wins a free bank
    step(4'b0000, 1'b0, "R8 idle");
    step(4'b1011, 1'b0, "R8 owner");
    check("R8 literal", 4'b1000);
    owner_en = 1'b0;
    step(4'b0000, 1'b0, "R8 done");

    // constrained random phases
    for (int ph = 0; ph < 40; ph++) begin
      req = '0; beat = 1'b0;
      step(4'b0000, 1'b0, "R2 phase idle");
      for (int m = 0; m < N; m++) budget_cfg[m*CW +: CW] = CW'($urandom_range(0, 5));
      owner_en = ($urandom_range(0, 2) == 0);
      owner_id = 2'($urandom_range(0, 3));
      for (int c = 0; c < 60; c++) begin
        logic [N-1:0] r;
        r = req;
        for (int m = 0; m < N; m++)
          if ($urandom_range(0, 7) == 0) r[m] = ~r[m];
        step(r, 1'($urandom_range(0, 1)), "R2 R3 R4 R7 R9 random");
      end
    end
    owner_en = 1'b0;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule